// File: doc/BRIEF.md
# Gated Square-Wave Tone Generator

This block makes an audible tone from a fast system clock. A free-running cycle counter sets the length of one tone period. A second threshold sets how many cycles of that period the one-bit output stays high. The output feeds a mono audio path, where an external low-pass filter turns the pulse train into a smooth waveform for a small speaker. With the default parameters, a 125 MHz clock gives a 220 Hz tone. One period is 568,181 cycles, which needs a 20-bit counter, and the default duty cycle is 50%.

A small selector code, usually wired to board switches, picks one of two settings. In frequency mode the code picks a harmonic of the base tone at 50% duty. In duty mode the tone stays at the base frequency and the code picks the high time. An enable input mutes the output. The enable is registered together with the wave, so the output changes only on clock edges. The code and the mode are taken in only at the end of a period, so a switch change never produces a partial or glitched period.

Top module: `tone_gen`

## Requirements
- R1: While `rst` is high, at each clock edge the counter clears and `audio_out` goes low. The first period after reset uses the base period at 50% duty.
- R2: In frequency mode (`duty_mode`=0) with code 0, the period is P = floor(CLK_HZ/BASE_HZ) cycles and the high time is floor(P/2) cycles.
- R3: In frequency mode with code k, the period is floor(CLK_HZ/(BASE_HZ*(k+1))) cycles and the high time is half of that period, rounded down.
- R4: In duty mode (`duty_mode`=1), the period is P.
  - Code 0 holds the output low.
  - The all-ones code gives a high time of P-1.
  - Any other code k gives a high time of floor(P*k/2^CODE_W).
- R5: Within each period the output is high first, for exactly the high time, and then low for the rest of the period.
- R6: The code and the mode are sampled only when the counter wraps. A change in the middle of a period does not alter that period's high or low length.
- R7: When `tone_en` is 0 at a clock edge, `audio_out` is 0 after that edge. The counter keeps running while the output is muted.
- R8: The counter counts from 0 to period-1 and then wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_en | input | 1 | Output enable; 0 mutes the output |
| duty_mode | input | 1 | 0: the code selects frequency; 1: the code selects duty |
| sel_code | input | CODE_W | Frequency or duty selector code |
| audio_out | output | 1 | Registered one-bit square wave |

## Verification
The bench uses a 120-cycle base period. It measures the high and low run lengths for every frequency code and every duty code.

Duty code 0 and the all-ones duty code are each checked on their own. An off-by-one threshold would stretch the all-ones code to a constant high, and it would turn code 0 into a one-cycle pulse.

A code change placed just after a rising edge checks that the current period keeps its old length. A design that applied the code at once would cut that period short.

A mute placed while the output is high checks that the output falls at the very next edge and stays low. Leaky gating would let pulses through.

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned BASE_HZ = 220,
  parameter int unsigned CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tone_en,
  input  logic              duty_mode,
  input  logic [CODE_W-1:0] sel_code,
  output logic              audio_out
);
  localparam int unsigned BASE_PERIOD = CLK_HZ / BASE_HZ;
  localparam int unsigned PER_W       = $clog2(BASE_PERIOD + 1);
  localparam int unsigned NCODE       = 1 << CODE_W;
  localparam logic [PER_W-1:0] BASE_P = PER_W'(BASE_PERIOD);

  logic [PER_W-1:0] per_tab [NCODE];
  logic [PER_W-1:0] cnt_q, per_q, high_q;
  logic [PER_W-1:0] per_nxt, high_nxt, cnt_inc;
  logic [PER_W+CODE_W-1:0] scaled;
  logic at_end;

  for (genvar g = 0; g < NCODE; g++) begin : g_per
    localparam int unsigned PG = BASE_PERIOD / (g + 1);
    assign per_tab[g] = PER_W'(PG);
  end

  assign scaled  = {{CODE_W{1'b0}}, BASE_P} * {{PER_W{1'b0}}, sel_code};
  assign at_end  = (cnt_q == per_q - PER_W'(1));
  assign cnt_inc = cnt_q + PER_W'(1);

  always_comb begin
    if (duty_mode) begin
      per_nxt = BASE_P;
      if (sel_code == '0)      high_nxt = '0;
      else if (sel_code == '1) high_nxt = BASE_P - PER_W'(1);
      else                     high_nxt = scaled[PER_W+CODE_W-1:CODE_W];
    end else begin
      per_nxt  = per_tab[sel_code];
      high_nxt = per_nxt >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      per_q     <= BASE_P;
      high_q    <= BASE_P >> 1;
      audio_out <= 1'b0;
    end else if (at_end) begin
      cnt_q     <= '0;
      per_q     <= per_nxt;
      high_q    <= high_nxt;
      audio_out <= tone_en && (high_nxt != '0);
    end else begin
      cnt_q     <= cnt_inc;
      audio_out <= tone_en && (cnt_inc < high_q);
    end
  end
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
  parameter int unsigned PER_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             tone_en,
  input logic             audio_out,
  input logic [PER_W-1:0] cnt_q,
  input logic [PER_W-1:0] per_q,
  input logic [PER_W-1:0] high_q
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!audio_out && cnt_q == '0));
  p_mute_r7: assert property (@(posedge clk) disable iff (rst) !tone_en |=> !audio_out);
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == per_q - PER_W'(1)) |=> (cnt_q == '0));
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != per_q - PER_W'(1)) |=> (cnt_q == $past(cnt_q) + PER_W'(1)));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != per_q - PER_W'(1)) |=> ($stable(per_q) && $stable(high_q)));
  p_shape_r5: assert property (@(posedge clk) disable iff (rst)
    (tone_en && cnt_q != per_q - PER_W'(1)) |=> (audio_out == (cnt_q < high_q)));
  p_high_bound_r4: assert property (@(posedge clk) disable iff (rst) 1'b1 |-> (high_q < per_q));
endmodule

bind tone_gen tone_gen_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .tone_en(tone_en), .audio_out(audio_out),
  .cnt_q(cnt_q), .per_q(per_q), .high_q(high_q)
);

// File: tb/tone_gen_bench.sv
`timescale 1ns/1ps
module tone_gen_bench;
  localparam int unsigned CLK_HZ  = 1200;
  localparam int unsigned BASE_HZ = 10;
  localparam int unsigned CODE_W  = 2;
  localparam int BASE = CLK_HZ / BASE_HZ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tone_en = 1'b0;
  logic duty_mode = 1'b0;
  logic [CODE_W-1:0] sel_code = '0;
  logic audio_out;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tone_gen #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ), .CODE_W(CODE_W)) u_tone_gen (
    .clk(clk), .rst(rst), .tone_en(tone_en), .duty_mode(duty_mode),
    .sel_code(sel_code), .audio_out(audio_out)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rise(output bit ok);
    bit prev;
    ok = 1'b0;
    prev = audio_out;
    for (int i = 0; i < 4 * BASE; i++) begin
      @(negedge clk);
      if (audio_out && !prev) begin ok = 1'b1; break; end
      prev = audio_out;
    end
  endtask

  task automatic count_runs(output int hi, output int lo);
    hi = 1;
    lo = 0;
    for (int i = 0; i < 4 * BASE; i++) begin
      @(negedge clk);
      if (audio_out) hi++; else break;
    end
    lo = 1;
    for (int i = 0; i < 4 * BASE; i++) begin
      @(negedge clk);
      if (!audio_out) lo++; else break;
    end
  endtask

  task automatic measure(input string req, input int exp_hi, input int exp_lo);
    bit ok;
    int hi, lo;
    wait_cycles(2 * BASE + 4);
    wait_rise(ok);
    check({req, " rise seen"}, int'(ok), 1);
    if (ok) begin
      count_runs(hi, lo);
      check({req, " high"}, hi, exp_hi);
      check({req, " low"}, lo, exp_lo);
    end
  endtask

  task automatic expect_low(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (audio_out) seen++;
    end
    check(req, seen, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    bit ok;
    int hi, lo;
    tone_en = 1'b1;
    wait_cycles(3);
    check("R1 reset holds output low", int'(audio_out), 0);
    @(negedge clk) rst = 1'b0;

    measure("R2 default tone", BASE / 2, BASE - BASE / 2);

    // R3 frequency sweep over every code
    for (int k = 0; k < (1 << CODE_W); k++) begin
      int p;
      p = BASE / (k + 1);
      sel_code = CODE_W'(k);
      measure($sformatf("R3 freq code %0d", k), p / 2, p - p / 2);
    end

    // R4 duty sweep: code 0 low, max code P-1, others scaled
    duty_mode = 1'b1;
    sel_code = '0;
    wait_cycles(2 * BASE + 4);
    expect_low("R4 duty code 0 stays low", 3 * BASE);
    for (int k = 1; k < (1 << CODE_W); k++) begin
      int h;
      h = (k == (1 << CODE_W) - 1) ? BASE - 1 : (BASE * k) >> CODE_W;
      sel_code = CODE_W'(k);
      measure($sformatf("R4 R5 duty code %0d", k), h, BASE - h);
    end

    // R6 code change just after the rise keeps the current period
    duty_mode = 1'b0;
    sel_code = '0;
    wait_cycles(2 * BASE + 4);
    wait_rise(ok);
    check("R6 rise seen", int'(ok), 1);
    sel_code = 2'd3;
    count_runs(hi, lo);
    check("R6 current high kept", hi, BASE / 2);
    check("R6 current low kept", lo, BASE - BASE / 2);
    count_runs(hi, lo);
    check("R6 R8 next high uses new code", hi, (BASE / 4) / 2);
    check("R6 R8 next low uses new code", lo, BASE / 4 - (BASE / 4) / 2);

    // R7 mute while high: low from the next edge
    sel_code = '0;
    wait_cycles(2 * BASE + 4);
    wait_rise(ok);
    tone_en = 1'b0;
    @(negedge clk);
    check("R7 mute at next edge", int'(audio_out), 0);
    expect_low("R7 muted stays low", 3 * BASE);
    tone_en = 1'b1;
    measure("R7 unmuted tone returns", BASE / 2, BASE - BASE / 2);

    // R1 reset mid-run
    rst = 1'b1;
    wait_cycles(2);
    check("R1 reset mid-run output low", int'(audio_out), 0);
    rst = 1'b0;
    duty_mode = 1'b1;
    sel_code = 2'd1;
    measure("R1 R4 after reset", (BASE * 1) >> CODE_W, BASE - ((BASE * 1) >> CODE_W));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule